// File: doc/BRIEF.md
# L1 Duplicate-Tag Invalidation Directory

This block sits beside a shared cache controller and serves as the coherence point for a small cluster of cores. Each core has a write-through L1 data cache, so no L1 ever holds modified data. The block keeps a direct-mapped copy of every L1's tags: one tag and one valid bit per core per set. Fill notices write this copy. Eviction notices clear it. Store commits are looked up against it.

When a core commits a store, the block checks the duplicate tags of all the other cores for the same line. Every core that holds the line gets an invalidate, and that core's duplicate entry is cleared. The storing core keeps its own entry, because its write-through L1 already has the new data. Each core's invalidate is held on its output until the core acknowledges it. A done pulse reports that the store has finished. Only one store is in flight at a time, and the store port is back-pressured until all of its invalidates are accepted.

Addresses are line addresses. The low `IDX_W` bits select the set and the upper `TAG_W` bits form the tag.

Top module: `l1_dup_dir`

## Requirements
- R1: After reset, `st_ready_o` is 1, `st_done_o` is 0 and `inv_valid_o` is all zeros. Every duplicate entry is invalid, so the first store finds no sharers.
- R2: A fill notice from core c for address a records tag(a) as valid for core c in set idx(a).
- R3: When a store is accepted (`st_valid_i` and `st_ready_o` high at a clock edge), `inv_valid_o` bit k rises on that edge for every core k other than the storer whose entry in idx(a) is valid with tag(a). At the same edge, `inv_addr_o` takes the store address. No bit of `inv_valid_o` rises at any other time.
- R4: The storing core never receives an invalidate for its own store, and its own duplicate entry is left unchanged by it.
- R5: Every entry that is invalidated by a store is cleared, so a repeat of that store finds no sharers.
- R6: Bit k of `inv_valid_o` stays high until `inv_ack_i[k]` is high at a clock edge. Acknowledges on cores with no pending invalidate have no effect.
- R7: `st_ready_o` is low from the edge that accepts a store with sharers until the edge that takes the last acknowledge. Stores offered in that window are not taken.
- R8: `st_done_o` is high for the cycle after an accepted store with no sharers, and for the cycle after the edge that takes the last acknowledge of a store with sharers. It is low in every other cycle.
- R9: An eviction notice from core c for address a clears core c's entry in idx(a) only if that entry holds tag(a). No invalidate is sent for an eviction.
- R10: A store finds no sharer in a core whose entry for the set holds a different tag.
- R11: When a fill and a store arrive in the same cycle, the store's lookup sees the directory as it was before that cycle, and the fill is written afterwards. The filled entry therefore ends up valid.
- R12: A fill replaces the core's previous tag in that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Fill notice strobe |
| fill_core_i | input | CORE_W | Core that loaded the line |
| fill_addr_i | input | AW | Line address loaded |
| st_valid_i | input | 1 | Store commit request |
| st_ready_o | output | 1 | Store port can accept |
| st_core_i | input | CORE_W | Storing core |
| st_addr_i | input | AW | Line address written |
| st_done_o | output | 1 | Store finished, all invalidates accepted |
| ev_valid_i | input | 1 | Eviction notice strobe |
| ev_core_i | input | CORE_W | Core that dropped the line |
| ev_addr_i | input | AW | Line address dropped |
| inv_valid_o | output | NCORE | Per-core invalidate request |
| inv_addr_o | output | AW | Line address to invalidate |
| inv_ack_i | input | NCORE | Per-core invalidate acknowledge |

## Verification
The bench first runs directed sequences. All four cores share one line, and the sharers then acknowledge in a staggered order; this separates the store's exclusion of its own core from the holding of invalidates that are still pending. Further sequences cover stale and matching evictions, a tag conflict in one set, a tag that is replaced by a later fill, a fill and a store arriving together, and a store offered while the port is busy. A long random phase then mixes fills, stores, evictions and acknowledges, including acknowledges on cores with nothing pending, over a few sets and two tags. This keeps collisions frequent and compares every output against a behavioural model.

// File: rtl/l1dd_pkg.sv
package l1dd_pkg;
  localparam int unsigned NCORE_DEF = 4;
  localparam int unsigned NSET_DEF  = 64;
  localparam int unsigned TAG_W_DEF = 8;

  typedef enum logic {ST_IDLE = 1'b0, ST_WAIT = 1'b1} st_state_e;
endpackage

// File: rtl/l1dd_tag_bank.sv
module l1dd_tag_bank #(
  parameter int unsigned NSET  = 64,
  parameter int unsigned TAG_W = 8,
  localparam int unsigned IDX_W = $clog2(NSET)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] lk_idx_i,
  input  logic [TAG_W-1:0] lk_tag_i,
  output logic             lk_hit_o,
  input  logic             clr_i,
  input  logic             fl_we_i,
  input  logic [IDX_W-1:0] fl_idx_i,
  input  logic [TAG_W-1:0] fl_tag_i,
  input  logic             ev_we_i,
  input  logic [IDX_W-1:0] ev_idx_i,
  input  logic [TAG_W-1:0] ev_tag_i
);
  logic [TAG_W-1:0] tag_q [NSET];
  logic [NSET-1:0]  vld_q;

  assign lk_hit_o = vld_q[lk_idx_i] && (tag_q[lk_idx_i] == lk_tag_i);

  always_ff @(posedge clk_i) begin
    if (fl_we_i) tag_q[fl_idx_i] <= fl_tag_i;
  end

  // fill is applied last: it wins over a same-cycle store clear or eviction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
    end else begin
      for (int s = 0; s < NSET; s++) begin
        if (fl_we_i && fl_idx_i == IDX_W'(s))
          vld_q[s] <= 1'b1;
        else if (clr_i && lk_idx_i == IDX_W'(s))
          vld_q[s] <= 1'b0;
        else if (ev_we_i && ev_idx_i == IDX_W'(s) && tag_q[s] == ev_tag_i)
          vld_q[s] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/l1dd_inv_ctrl.sv
module l1dd_inv_ctrl
  import l1dd_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned AW    = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             st_acc_i,
  input  logic [AW-1:0]    st_addr_i,
  input  logic [NCORE-1:0] hit_i,
  input  logic [NCORE-1:0] ack_i,
  output logic             ready_o,
  output logic             done_o,
  output logic [NCORE-1:0] inv_valid_o,
  output logic [AW-1:0]    inv_addr_o
);
  st_state_e        state_q;
  logic [NCORE-1:0] pend_q, pend_left;
  logic [AW-1:0]    addr_q;
  logic             done_q;

  assign pend_left = pend_q & ~ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= '0;
      addr_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (st_acc_i) begin
          addr_q <= st_addr_i;
          if (hit_i == '0) begin
            done_q <= 1'b1;
          end else begin
            pend_q  <= hit_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          pend_q <= pend_left;
          if (pend_left == '0) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = (state_q == ST_IDLE);
  assign done_o      = done_q;
  assign inv_valid_o = pend_q;
  assign inv_addr_o  = addr_q;
endmodule

// File: rtl/l1_dup_dir.sv
module l1_dup_dir
  import l1dd_pkg::*;
#(
  parameter int unsigned NCORE = NCORE_DEF,
  parameter int unsigned NSET  = NSET_DEF,
  parameter int unsigned TAG_W = TAG_W_DEF,
  localparam int unsigned IDX_W  = $clog2(NSET),
  localparam int unsigned CORE_W = $clog2(NCORE),
  localparam int unsigned AW     = TAG_W + IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_valid_i,
  input  logic [CORE_W-1:0] fill_core_i,
  input  logic [AW-1:0]     fill_addr_i,
  input  logic              st_valid_i,
  output logic              st_ready_o,
  input  logic [CORE_W-1:0] st_core_i,
  input  logic [AW-1:0]     st_addr_i,
  output logic              st_done_o,
  input  logic              ev_valid_i,
  input  logic [CORE_W-1:0] ev_core_i,
  input  logic [AW-1:0]     ev_addr_i,
  output logic [NCORE-1:0]  inv_valid_o,
  output logic [AW-1:0]     inv_addr_o,
  input  logic [NCORE-1:0]  inv_ack_i
);
  logic             st_acc;
  logic [NCORE-1:0] hit_raw, hit_oth;

  assign st_acc = st_valid_i && st_ready_o;

  for (genvar g = 0; g < NCORE; g++) begin : g_core
    assign hit_oth[g] = hit_raw[g] && (st_core_i != CORE_W'(g));

    l1dd_tag_bank #(.NSET(NSET), .TAG_W(TAG_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .lk_idx_i (st_addr_i[IDX_W-1:0]),
      .lk_tag_i (st_addr_i[AW-1:IDX_W]),
      .lk_hit_o (hit_raw[g]),
      .clr_i    (st_acc && hit_oth[g]),
      .fl_we_i  (fill_valid_i && fill_core_i == CORE_W'(g)),
      .fl_idx_i (fill_addr_i[IDX_W-1:0]),
      .fl_tag_i (fill_addr_i[AW-1:IDX_W]),
      .ev_we_i  (ev_valid_i && ev_core_i == CORE_W'(g)),
      .ev_idx_i (ev_addr_i[IDX_W-1:0]),
      .ev_tag_i (ev_addr_i[AW-1:IDX_W])
    );
  end

  l1dd_inv_ctrl #(.NCORE(NCORE), .AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .st_acc_i    (st_acc),
    .st_addr_i   (st_addr_i),
    .hit_i       (hit_oth),
    .ack_i       (inv_ack_i),
    .ready_o     (st_ready_o),
    .done_o      (st_done_o),
    .inv_valid_o (inv_valid_o),
    .inv_addr_o  (inv_addr_o)
  );
endmodule

// File: rtl/l1_dup_dir_chk.sv
module l1_dup_dir_chk #(
  parameter int unsigned NCORE  = 4,
  parameter int unsigned CORE_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              st_valid_i,
  input logic              st_ready_o,
  input logic [CORE_W-1:0] st_core_i,
  input logic              st_done_o,
  input logic [NCORE-1:0]  inv_valid_o,
  input logic [NCORE-1:0]  inv_ack_i
);
  AST_INV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_o & ~inv_ack_i) != '0 |=> (($past(inv_valid_o & ~inv_ack_i) & ~inv_valid_o) == '0)); // R6

  AST_SELF_NOINV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_valid_i && st_ready_o) |=> !inv_valid_o[$past(st_core_i)]); // R4

  AST_BUSY_NOREADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_o != '0) |-> !st_ready_o); // R7

  AST_DONE_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_done_o |-> (inv_valid_o == '0) && st_ready_o); // R8

  AST_INV_ONLY_ON_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_valid_o != '0) && ($past(inv_valid_o) == '0) |-> $past(st_valid_i && st_ready_o)); // R3
endmodule

bind l1_dup_dir l1_dup_dir_chk #(.NCORE(NCORE), .CORE_W(CORE_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .st_valid_i  (st_valid_i),
  .st_ready_o  (st_ready_o),
  .st_core_i   (st_core_i),
  .st_done_o   (st_done_o),
  .inv_valid_o (inv_valid_o),
  .inv_ack_i   (inv_ack_i)
);

// File: tb/l1_dup_dir_tb.sv
module l1_dup_dir_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCORE = 4, NSET = 64, TAG_W = 8, IDX_W = 6, CW = 2, AW = 14;

  logic clk = 1'b0, rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic fill_valid, st_valid, ev_valid, st_ready, st_done;
  logic [CW-1:0] fill_core, st_core, ev_core;
  logic [AW-1:0] fill_addr, st_addr, ev_addr, inv_addr;
  logic [NCORE-1:0] inv_valid, inv_ack;

  l1_dup_dir u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_core_i(fill_core), .fill_addr_i(fill_addr),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_core_i(st_core), .st_addr_i(st_addr),
    .st_done_o(st_done),
    .ev_valid_i(ev_valid), .ev_core_i(ev_core), .ev_addr_i(ev_addr),
    .inv_valid_o(inv_valid), .inv_addr_o(inv_addr), .inv_ack_i(inv_ack)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  logic [TAG_W-1:0] m_tag [NCORE][NSET];
  bit               m_vld [NCORE][NSET];
  bit               m_busy, m_done;
  logic [NCORE-1:0] m_pend;
  logic [AW-1:0]    m_addr;

  function automatic logic [AW-1:0] mk(int t, int s);
    return {t[TAG_W-1:0], s[IDX_W-1:0]};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R7", "st_ready", 32'(st_ready), 32'(!m_busy));
    chk("R8", "st_done", 32'(st_done), 32'(m_done));
    chk("R3", "inv_valid", 32'(inv_valid), 32'(m_pend));
    if (m_pend != 0) chk("R3", "inv_addr", 32'(inv_addr), 32'(m_addr));
  endtask

  task automatic idle();
    fill_valid = 0; st_valid = 0; ev_valid = 0; inv_ack = '0;
    fill_core = '0; st_core = '0; ev_core = '0;
    fill_addr = '0; st_addr = '0; ev_addr = '0;
  endtask

  task automatic model_step();
    logic [NCORE-1:0] hits;
    int s, ec, es;
    m_done = 0;
    if (m_busy) begin
      m_pend = m_pend & ~inv_ack;
      if (m_pend == 0) begin m_busy = 0; m_done = 1; end
    end else if (st_valid) begin
      s = int'(st_addr[IDX_W-1:0]);
      hits = '0;
      for (int c = 0; c < NCORE; c++)
        if (c != int'(st_core) && m_vld[c][s] && m_tag[c][s] == st_addr[AW-1:IDX_W]) begin
          hits[c] = 1'b1;
          m_vld[c][s] = 0;
        end
      m_addr = st_addr;
      if (hits == 0) m_done = 1;
      else begin m_busy = 1; m_pend = hits; end
    end
    if (ev_valid) begin
      ec = int'(ev_core); es = int'(ev_addr[IDX_W-1:0]);
      if (m_vld[ec][es] && m_tag[ec][es] == ev_addr[AW-1:IDX_W]) m_vld[ec][es] = 0;
    end
    if (fill_valid) begin
      m_tag[fill_core][fill_addr[IDX_W-1:0]] = fill_addr[AW-1:IDX_W];
      m_vld[fill_core][fill_addr[IDX_W-1:0]] = 1;
    end
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    cmp_all();
    idle();
  endtask

  task automatic do_fill(int c, logic [AW-1:0] a);
    fill_valid = 1; fill_core = CW'(c); fill_addr = a; tick();
  endtask
  task automatic do_store(int c, logic [AW-1:0] a);
    st_valid = 1; st_core = CW'(c); st_addr = a; tick();
  endtask
  task automatic do_evict(int c, logic [AW-1:0] a);
    ev_valid = 1; ev_core = CW'(c); ev_addr = a; tick();
  endtask
  task automatic do_ack(logic [NCORE-1:0] m);
    inv_ack = m; tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a_a, a_b, a_c;
    idle();
    rst_n = 0;
    m_busy = 0; m_done = 0; m_pend = '0; m_addr = '0;
    for (int c = 0; c < NCORE; c++)
      for (int s = 0; s < NSET; s++) begin m_vld[c][s] = 0; m_tag[c][s] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "st_ready", 32'(st_ready), 32'd1);
    chk("R1", "st_done", 32'(st_done), 32'd0);
    chk("R1", "inv_valid", 32'(inv_valid), 32'd0);
    a_a = mk(3, 5); a_b = mk(9, 12); a_c = mk(1, 20);
    do_store(2, a_a);
    chk("R1", "empty directory done", 32'(st_done), 32'd1);

    // R2 R3 R4: all cores share a line, core 0 stores
    for (int c = 0; c < NCORE; c++) do_fill(c, a_a);
    do_store(0, a_a);
    chk("R3", "sharers invalidated", 32'(inv_valid), 32'b1110);
    chk("R3", "inv address", 32'(inv_addr), 32'(a_a));
    chk("R7", "busy not ready", 32'(st_ready), 32'd0);
    do_ack(4'b0011);
    chk("R6", "unacked held", 32'(inv_valid), 32'b1100);
    chk("R8", "no early done", 32'(st_done), 32'd0);
    // R7: offered store while busy is not taken
    st_valid = 1; st_core = 2'd1; st_addr = a_b; tick();
    chk("R7", "store refused", 32'(inv_addr), 32'(a_a));
    do_ack(4'b1100);
    chk("R8", "done after last ack", 32'(st_done), 32'd1);
    chk("R6", "all cleared", 32'(inv_valid), 32'd0);
    do_store(2, a_a);
    chk("R4", "storer entry kept", 32'(inv_valid), 32'b0001);
    do_ack(4'b0001);
    do_store(0, a_a);
    chk("R5", "entries cleared", 32'(inv_valid), 32'd0);
    chk("R5", "no-sharer done", 32'(st_done), 32'd1);

    // R9 eviction
    do_fill(1, a_b);
    do_evict(1, mk(8, 12));
    do_store(3, a_b);
    chk("R9", "mismatched evict ignored", 32'(inv_valid), 32'b0010);
    do_ack(4'b0010);
    do_fill(1, a_b);
    do_evict(1, a_b);
    chk("R9", "evict sends nothing", 32'(inv_valid), 32'd0);
    do_store(3, a_b);
    chk("R9", "evicted entry gone", 32'(inv_valid), 32'd0);

    // R10 different tag in the same set
    do_fill(2, mk(4, 5));
    do_store(0, a_a);
    chk("R10", "tag mismatch", 32'(inv_valid), 32'd0);

    // R12 fill replaces tag
    do_fill(2, mk(1, 7));
    do_fill(2, mk(2, 7));
    do_store(0, mk(1, 7));
    chk("R12", "old tag gone", 32'(inv_valid), 32'd0);
    do_store(0, mk(2, 7));
    chk("R12", "new tag held", 32'(inv_valid), 32'b0100);
    do_ack(4'b0100);

    // R11 fill and store in the same cycle
    do_fill(1, a_c);
    fill_valid = 1; fill_core = 2'd1; fill_addr = a_c;
    st_valid = 1; st_core = 2'd0; st_addr = a_c;
    tick();
    chk("R11", "store sees prior entry", 32'(inv_valid), 32'b0010);
    do_ack(4'b0010);
    do_store(0, a_c);
    chk("R11", "fill written after store", 32'(inv_valid), 32'b0010);
    do_ack(4'b1111);
    chk("R6", "spurious acks harmless", 32'(st_ready), 32'd1);

    // random mix, lockstep compared
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 2) == 0) begin
        st_valid = 1; st_core = CW'($urandom_range(0, 3));
        st_addr = mk($urandom_range(0, 1), $urandom_range(0, 3));
      end
      if ($urandom_range(0, 1) == 0) begin
        fill_valid = 1; fill_core = CW'($urandom_range(0, 3));
        fill_addr = mk($urandom_range(0, 1), $urandom_range(0, 3));
      end
      if ($urandom_range(0, 3) == 0) begin
        ev_valid = 1; ev_core = CW'($urandom_range(0, 3));
        ev_addr = mk($urandom_range(0, 1), $urandom_range(0, 3));
      end
      inv_ack = NCORE'($urandom_range(0, 15));
      tick();
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule